// File: doc/BRIEF.md
# Streaming Loop Accumulator with Address Sequencer

This block replaces a small, hot software loop with hardware. Software sets the run up through a small register file: a starting word address, an element count, an initial accumulator value, and a mode word. The mode word picks the address direction, whether each result is written back, whether reads are streamed back-to-back, and which combining operation is used. Software then writes the start bit and may put the processor to sleep. The block fetches each element through a request/grant memory port into an input register. A purely combinational kernel folds that input into an accumulator register in one cycle. When the write-back mode is on, the block stores the running accumulator back to the address the element came from.

All address arithmetic and loop counting happen in the sequencer, so the kernel only ever sees two operands. When the last element has been handled, the block raises a sticky interrupt. Software clears it after reading the accumulator back.

Top module: `loop_accel`

## Requirements
- R1: After reset, every configuration register, the accumulator and the input register read 0, `irq` is 0 and `mem_req` is 0.
- R2: Register map (word index on `cfg_addr`): 0 start address (AW bits), 1 element count (CW bits), 2 mode (5 bits), 3 initial accumulator value (DW bits), 4 command/status, 5 accumulator, 6 input register, 7 reads 0. Registers 0 to 3 read back the low bits that were written, zero-extended.
- R3: Writing 1 to bit 0 of register 4 while idle starts a run. The start copies the initial value into the accumulator and captures the address, count and mode. A start written during a run is ignored. Configuration writes during a run do not change that run.
- R4: Each element is read with `mem_req`=1 and `mem_we`=0. The request, address and direction stay stable until `mem_gnt`. The word on `mem_rdata` in the granted cycle is loaded into the input register.
- R5: After each fetched element, accumulator = accumulator OP input. OP is selected by mode bits [4:3]: 0 add modulo 2^DW, 1 xor, 2 and, 3 or.
- R6: Mode bit 0 = 0 reads start, start+1, start+2, and so on. Mode bit 0 = 1 reads start, start-1, and so on. Addresses wrap modulo 2^AW.
- R7: With mode bit 1 = 1, after each accumulate the block writes the new accumulator to the address just read (`mem_we`=1, data on `mem_wdata`) before the next fetch. With mode bit 1 = 0, the block never writes.
- R8: In single mode (mode bit 2 = 0), and in every run with write-back on, `mem_req` is low in the cycle after each read grant. With grant always high, a read-only run of N>0 elements raises `irq` 2N+1 cycles after the start edge. A write-back run of N>0 elements raises it 3N+1 cycles after the start edge.
- R9: In block mode (mode bit 2 = 1) with write-back off, `mem_req` stays high between reads. Only the last read grant is followed by a low request. With grant always high, `irq` rises N+2 cycles after the start edge.
- R10: When a run completes, `irq` and status bit 1 go to 1 and stay there until bit 1 of register 4 is written with 1. Completion wins over a clear written in the same cycle.
- R11: A count of 0 makes no memory request and raises `irq` one cycle after the start edge. The accumulator still takes the initial value.
- R12: Status bit 0 (busy) is 1 from the start edge until the cycle in which `irq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data (accumulator) |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_rdata | input | DW | Read data, valid in the granted cycle |
| irq | output | 1 | Sticky completion interrupt |

## Verification
Some properties are checked on every cycle: a pending request holds its address and direction until granted, and single-mode reads drop the request after each grant. The sticky interrupt persists until it is cleared. The accumulator and input register hold whenever no load is issued, and a zero count gives a request-free completion. The scenarios cover the things a property cannot express. They sweep every operation, direction, write-back and request mode over several lengths and two grant patterns. They show the accumulated value, the address order including wrap, the memory contents after write-back, and the run length in cycles. Directed scenarios cover a restart attempted mid-run and a clear that collides with completion.

// File: rtl/loop_accel_pkg.sv
package loop_accel_pkg;

    localparam int REG_AW = 3;
    localparam int CTRL_W = 5;

    localparam logic [REG_AW-1:0] RA_BASE  = 3'd0;
    localparam logic [REG_AW-1:0] RA_COUNT = 3'd1;
    localparam logic [REG_AW-1:0] RA_MODE  = 3'd2;
    localparam logic [REG_AW-1:0] RA_INIT  = 3'd3;
    localparam logic [REG_AW-1:0] RA_CMD   = 3'd4;
    localparam logic [REG_AW-1:0] RA_ACC   = 3'd5;
    localparam logic [REG_AW-1:0] RA_IN    = 3'd6;

    typedef enum logic [1:0] {
        K_ADD = 2'd0,
        K_XOR = 2'd1,
        K_AND = 2'd2,
        K_OR  = 2'd3
    } kern_op_e;

    // packed order gives op[4:3], burst[2], wb[1], down[0]
    typedef struct packed {
        kern_op_e op;
        logic     burst;
        logic     wb;
        logic     down;
    } run_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_COMPUTE,
        S_WRITEBACK,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/loop_accel_kernel.sv
module loop_accel_kernel
    import loop_accel_pkg::*;
#(
    parameter int DW = 32
) (
    input  kern_op_e      op,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] acc_out
);
    always_comb begin
        unique case (op)
            K_ADD:   acc_out = acc_in + operand;
            K_XOR:   acc_out = acc_in ^ operand;
            K_AND:   acc_out = acc_in & operand;
            default: acc_out = acc_in | operand;
        endcase
    end
endmodule

// File: rtl/loop_accel_regs.sv
module loop_accel_regs
    import loop_accel_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              busy,
    input  logic              irq,
    input  logic [DW-1:0]     acc,
    input  logic [DW-1:0]     inreg,
    output logic [AW-1:0]     base_o,
    output logic [CW-1:0]     count_o,
    output run_mode_t         mode_o,
    output logic [DW-1:0]     init_o,
    output logic              start_o,
    output logic              irq_clr_o
);
    logic [AW-1:0] base_q;
    logic [CW-1:0] count_q;
    run_mode_t     mode_q;
    logic [DW-1:0] init_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            count_q <= '0;
            mode_q  <= '0;
            init_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                RA_BASE:  base_q  <= cfg_wdata[AW-1:0];
                RA_COUNT: count_q <= cfg_wdata[CW-1:0];
                RA_MODE:  mode_q  <= run_mode_t'(cfg_wdata[CTRL_W-1:0]);
                RA_INIT:  init_q  <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    assign start_o   = cfg_we && (cfg_addr == RA_CMD) && cfg_wdata[0];
    assign irq_clr_o = cfg_we && (cfg_addr == RA_CMD) && cfg_wdata[1];

    always_comb begin
        case (cfg_addr)
            RA_BASE:  cfg_rdata = DW'(base_q);
            RA_COUNT: cfg_rdata = DW'(count_q);
            RA_MODE:  cfg_rdata = DW'(mode_q);
            RA_INIT:  cfg_rdata = init_q;
            RA_CMD:   cfg_rdata = DW'({irq, busy});
            RA_ACC:   cfg_rdata = acc;
            RA_IN:    cfg_rdata = inreg;
            default:  cfg_rdata = '0;
        endcase
    end

    assign base_o  = base_q;
    assign count_o = count_q;
    assign mode_o  = mode_q;
    assign init_o  = init_q;
endmodule

// File: rtl/loop_accel_seq.sv
module loop_accel_seq
    import loop_accel_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          irq_clr,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  run_mode_t     mode,
    input  logic          mem_gnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          load_init,
    output logic          load_in,
    output logic          acc_en,
    output logic          busy,
    output logic          irq,
    output kern_op_e      run_op
);
    seq_state_e    state, nxt;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] remain;
    run_mode_t     run_mode;
    logic          pend;
    logic          accept;
    logic          stream;
    logic          step_now;

    assign accept    = (state == S_IDLE) && start;
    assign stream    = run_mode.burst && !run_mode.wb;
    assign load_in   = (state == S_FETCH) && mem_gnt;
    assign load_init = accept;
    assign step_now  = (load_in && !run_mode.wb) || ((state == S_WRITEBACK) && mem_gnt);

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:      if (start) nxt = (count == '0) ? S_DONE : S_FETCH;
            S_FETCH:     if (mem_gnt)
                             nxt = (remain == CW'(1) || !stream) ? S_COMPUTE : S_FETCH;
            S_COMPUTE:   nxt = run_mode.wb ? S_WRITEBACK
                                           : ((remain == '0) ? S_DONE : S_FETCH);
            S_WRITEBACK: if (mem_gnt) nxt = (remain == '0) ? S_DONE : S_FETCH;
            S_DONE:      nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            run_mode <= '0;
            pend     <= 1'b0;
            irq      <= 1'b0;
        end else begin
            state <= nxt;
            pend  <= load_in;
            if (accept) begin
                cur_addr <= base;
                remain   <= count;
                run_mode <= mode;
            end else begin
                if (load_in)  remain   <= remain - CW'(1);
                if (step_now) cur_addr <= run_mode.down ? cur_addr - AW'(1)
                                                        : cur_addr + AW'(1);
            end
            if (state == S_DONE) irq <= 1'b1;
            else if (irq_clr)    irq <= 1'b0;
        end
    end

    assign mem_req  = (state == S_FETCH) || (state == S_WRITEBACK);
    assign mem_we   = (state == S_WRITEBACK);
    assign mem_addr = cur_addr;
    assign acc_en   = pend;
    assign busy     = (state != S_IDLE);
    assign run_op   = run_mode.op;

    // R4: an ungranted request keeps its address and direction
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8: outside streaming, a read grant is followed by an idle request cycle
    a_r8_single_gap: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_gnt && !mem_we && !stream |=> !mem_req);

    // R10: interrupt is sticky until cleared
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_clr |=> irq);

    // R11: zero count completes without touching memory
    a_r11_zero_count: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) && start && (count == '0) |=> !mem_req ##1 irq);
endmodule

// File: rtl/loop_accel_datapath.sv
module loop_accel_datapath
    import loop_accel_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_init,
    input  logic [DW-1:0] init_val,
    input  logic          load_in,
    input  logic [DW-1:0] rdata,
    input  logic          acc_en,
    input  kern_op_e      op,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] inreg
);
    logic [DW-1:0] acc_next;

    loop_accel_kernel #(.DW(DW)) u_kernel (
        .op      (op),
        .acc_in  (acc),
        .operand (inreg),
        .acc_out (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            inreg <= '0;
        end else begin
            if (load_in)        inreg <= rdata;
            if (load_init)      acc   <= init_val;
            else if (acc_en)    acc   <= acc_next;
        end
    end

    // R5: accumulator moves only on a start or an accumulate step
    a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !load_init && !acc_en |=> $stable(acc));

    // R4: input register changes only on a read grant
    a_r4_in_hold: assert property (@(posedge clk) disable iff (rst)
        !load_in |=> $stable(inreg));
endmodule

// File: rtl/loop_accel.sv
module loop_accel
    import loop_accel_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_gnt,
    input  logic [DW-1:0]     mem_rdata,
    output logic              irq
);
    logic [AW-1:0] base;
    logic [CW-1:0] count;
    run_mode_t     mode;
    logic [DW-1:0] init_val;
    logic          start, irq_clr;
    logic          load_init, load_in, acc_en, busy;
    kern_op_e      run_op;
    logic [DW-1:0] acc, inreg;

    loop_accel_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .irq       (irq),
        .acc       (acc),
        .inreg     (inreg),
        .base_o    (base),
        .count_o   (count),
        .mode_o    (mode),
        .init_o    (init_val),
        .start_o   (start),
        .irq_clr_o (irq_clr)
    );

    loop_accel_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .irq_clr   (irq_clr),
        .base      (base),
        .count     (count),
        .mode      (mode),
        .mem_gnt   (mem_gnt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .load_init (load_init),
        .load_in   (load_in),
        .acc_en    (acc_en),
        .busy      (busy),
        .irq       (irq),
        .run_op    (run_op)
    );

    loop_accel_datapath #(.DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load_init (load_init),
        .init_val  (init_val),
        .load_in   (load_in),
        .rdata     (mem_rdata),
        .acc_en    (acc_en),
        .op        (run_op),
        .acc       (acc),
        .inreg     (inreg)
    );

    assign mem_wdata = acc;
endmodule

// File: tb/loop_accel_tb.sv
module loop_accel_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        mem_req, mem_we, mem_gnt, irq;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    loop_accel u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench memory and monitors (single driver)
    logic [31:0] mem [256];
    logic [15:0] rd_log [64];
    int          rd_n, wr_n, gap_n;
    logic        prev_rg;
    logic        mon_clr = 1'b0;
    logic [31:0] seed = 32'h0;
    logic        gmode = 1'b0;
    logic [7:0]  gtick = 8'h0;

    function automatic logic [31:0] pat(int i, logic [31:0] s);
        return (32'(i) * 32'h9E3779B1) ^ s ^ (32'(i) << 20);
    endfunction

    assign mem_gnt   = mem_req && (!gmode || gtick[0]);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        gtick <= gtick + 8'd1;
        if (mon_clr) begin
            rd_n <= 0; wr_n <= 0; gap_n <= 0; prev_rg <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
        end else begin
            if (mem_req && mem_gnt && mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_n <= wr_n + 1;
            end
            if (mem_req && mem_gnt && !mem_we) begin
                if (rd_n < 64) rd_log[rd_n] <= mem_addr;
                rd_n <= rd_n + 1;
            end
            prev_rg <= mem_req && mem_gnt && !mem_we;
            if (prev_rg && !mem_req) gap_n <= gap_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // golden model
    logic [31:0] gm [256];
    logic [15:0] ex_addr [64];
    logic [31:0] ex_acc, ex_in;

    function automatic logic [31:0] kern(logic [1:0] op, logic [31:0] a, logic [31:0] b);
        case (op)
            2'd0: return a + b;
            2'd1: return a ^ b;
            2'd2: return a & b;
            default: return a | b;
        endcase
    endfunction

    task automatic model(input logic [1:0] op, input logic dir, input logic wb,
                         input int n, input logic [15:0] base, input logic [31:0] init);
        logic [15:0] a;
        for (int i = 0; i < 256; i++) gm[i] = pat(i, seed);
        ex_acc = init;
        ex_in  = 32'h0;
        a = base;
        for (int k = 0; k < n; k++) begin
            ex_addr[k] = a;
            ex_in  = gm[a[7:0]];
            ex_acc = kern(op, ex_acc, ex_in);
            if (wb) gm[a[7:0]] = ex_acc;
            a = dir ? a - 16'd1 : a + 16'd1;
        end
    endtask

    task automatic prep(input logic [31:0] s, input logic g);
        seed = s; gmode = g;
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        while (!irq && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!irq) begin
            n_chk++; n_fail++;
            $display("FAIL R10: watchdog, actual irq 0 expected 1");
        end
    endtask

    task automatic run_case(input logic [1:0] op, input logic dir, input logic wb,
                            input logic blk, input int n, input logic g, input int idx);
        logic [15:0] base;
        logic [31:0] init, d;
        int cyc, exp_cyc, exp_gap, bad;
        base = dir ? 16'h0002 : 16'h00FD;
        init = 32'hA5A5_0F0F ^ 32'(idx * 7919);
        prep(32'h1357_9BDF ^ 32'(idx), g);
        model(op, dir, wb, n, base, init);
        wr(3'd0, {16'h0, base});
        wr(3'd1, 32'(n));
        wr(3'd2, {27'h0, op, blk, wb, dir});
        wr(3'd3, init);
        wr(3'd4, 32'h1);
        cfg_addr = 3'd4;
        #1 check("R12 busy after start", {31'h0, cfg_rdata[0]}, 32'h1);
        wait_irq(cyc);
        if (!wb) exp_cyc = (n == 0) ? 1 : (blk ? n + 2 : 2 * n + 1);
        else     exp_cyc = (n == 0) ? 1 : 3 * n + 1;
        exp_gap = (n == 0) ? 0 : ((blk && !wb) ? 1 : n);
        if (!g) check(blk && !wb ? "R9 cycles to irq" : "R8 cycles to irq", 32'(cyc), 32'(exp_cyc));
        check(blk && !wb ? "R9 request gaps" : "R8 request gaps", 32'(gap_n), 32'(exp_gap));
        rd(3'd4, d);
        check("R10/R12 status after run", d, 32'h2);
        rd(3'd5, d);
        check("R5 accumulator", d, ex_acc);
        if (n > 0) begin
            rd(3'd6, d);
            check("R4 input register", d, ex_in);
        end
        check("R6/R11 read count", 32'(rd_n), 32'(n));
        for (int k = 0; k < n; k++) check("R6 read address", {16'h0, rd_log[k]}, {16'h0, ex_addr[k]});
        check("R7 write count", 32'(wr_n), wb ? 32'(n) : 32'h0);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== gm[i]) bad++;
        check("R7 memory image", 32'(bad), 32'h0);
        wr(3'd4, 32'h2);
        check("R10 irq cleared", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cyc, idx;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 mem_req", {31'h0, mem_req}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 register zero", d, 32'h0);
        end

        // R2 readback and masking
        wr(3'd0, 32'h1234_ABCD); rd(3'd0, d); check("R2 base", d, 32'h0000_ABCD);
        wr(3'd1, 32'h0001_2345); rd(3'd1, d); check("R2 count", d, 32'h0000_2345);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); check("R2 mode", d, 32'h0000_001F);
        wr(3'd3, 32'hDEAD_BEEF); rd(3'd3, d); check("R2 init", d, 32'hDEAD_BEEF);
        rd(3'd7, d); check("R2 unused index", d, 32'h0);

        // sweep: operation x direction x write-back x request mode x length x grant pattern
        idx = 0;
        for (int g = 0; g < 2; g++)
            for (int op = 0; op < 4; op++)
                for (int dir = 0; dir < 2; dir++)
                    for (int wb = 0; wb < 2; wb++)
                        for (int blk = 0; blk < 2; blk++)
                            for (int ni = 0; ni < 4; ni++) begin
                                run_case(2'(op), 1'(dir), 1'(wb), 1'(blk),
                                         (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 2 : 5,
                                         1'(g), idx);
                                idx++;
                            end

        // R3: restart and reconfiguration during a run are ignored
        prep(32'h0BAD_F00D, 1'b1);
        model(2'd0, 1'b0, 1'b0, 5, 16'h0020, 32'h7);
        wr(3'd0, 32'h20); wr(3'd1, 32'd5); wr(3'd2, 32'h0); wr(3'd3, 32'h7);
        wr(3'd4, 32'h1);
        repeat (2) @(negedge clk);
        wr(3'd0, 32'h80); wr(3'd3, 32'h0); wr(3'd2, {27'h0, 2'd1, 3'b100}); wr(3'd1, 32'd2);
        wr(3'd4, 32'h1);
        wait_irq(cyc);
        rd(3'd5, d);      check("R3 restart ignored accumulator", d, ex_acc);
        check("R3 restart ignored reads", 32'(rd_n), 32'd5);
        check("R3 first address kept", {16'h0, rd_log[0]}, 32'h20);
        wr(3'd4, 32'h2);
        // new configuration now takes effect
        prep(32'h0BAD_F00D, 1'b0);
        model(2'd1, 1'b0, 1'b0, 2, 16'h0080, 32'h0);
        wr(3'd4, 32'h1);
        wait_irq(cyc);
        rd(3'd5, d);      check("R3 next run uses new config", d, ex_acc);
        wr(3'd4, 32'h2);

        // R10/R11: clear colliding with zero-count completion
        wr(3'd1, 32'h0); wr(3'd3, 32'h55AA_33CC);
        prep(32'h1, 1'b0);
        wr(3'd4, 32'h1);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h2;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R10 completion beats clear", {31'h0, irq}, 32'h1);
        check("R11 zero count no request", 32'(rd_n + wr_n), 32'h0);
        rd(3'd5, d);      check("R11 accumulator takes init", d, 32'h55AA_33CC);
        wr(3'd4, 32'h2);
        check("R10 later clear", {31'h0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule